// File: doc/BRIEF.md
# Cache Tour Reuse Classifier

This block sits beside a cache and follows each line through one tour: the span from the fill that brings a block in until the eviction that removes it. For every resident line it keeps a bitmap of the words touched so far and a flag that is raised as soon as any word is touched a second time. When the line is evicted, the block emits a one-cycle record. The record gives the line index, a two-bit reuse class and the tour length. The tour length is the number of cache accesses handled anywhere in the cache while that line was resident.

The reuse class has two independent parts. The temporal part is set when some word was reused. The spatial part is set when more than one distinct word was used. The block keeps a saturating count of finished tours for each of the four classes. It also keeps a live census of how many resident lines currently fall into each class. Both can be read at any time on flat output vectors. The cache data and tag arrays are outside this block. It only sees fill, hit-access and evict events.

Top module: `tour_reuse_classifier`

## Requirements
- R1: A fill to a non-resident line makes it resident, marks the filled word as used once, clears its reuse flag, and counts as one handled access.
- R2: The temporal bit (ev_class[1]) is 1 when, during the tour, an access (or the fill) hit a word already marked used; otherwise it is 0.
- R3: The spatial bit (ev_class[0]) is 1 when two or more distinct words were used during the tour, and 0 when at most one was used.
- R4: An evict of a resident line raises ev_valid for exactly one cycle after the evicting clock edge, with ev_line equal to the evicted index and ev_class encoded {temporal, spatial}: 00, 01, 10 or 11. The line then stops being resident.
- R5: ev_length equals the number of handled fills and accesses, counted over the whole cache, from the line's own fill (inclusive) up to the evict.
- R6: Accesses to non-resident lines, evicts of non-resident lines and fills to resident lines are ignored: they change no state, produce no record and are not counted as handled accesses.
- R7: Only one event is taken per cycle. An asserted evict_valid blocks fill and access in that cycle, even when the evict itself is ignored. An asserted fill_valid blocks access.
- R8: Each finished tour increments the tour counter of its class, held in tour_cnt[c*CNT_W +: CNT_W] for class code c. The counter sticks at its all-ones value.
- R9: clr_cnt zeroes all four tour counters at the next edge and overrides an increment in the same cycle. It does not touch residency or line state.
- R10: res_cnt[c*RES_W +: RES_W] gives the number of resident lines whose current {temporal, spatial} state equals c. It is sampled from the line state as it stood before the previous clock edge.
- R11: Synchronous active-high reset clears every line, the access clock, all counters and ev_valid.
- R12: The access clock that stamps tour starts saturates at its all-ones value. Lengths are then computed as the saturated clock minus the stored start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_cnt | input | 1 | Clear the per-class tour counters |
| fill_valid | input | 1 | A line is being allocated |
| fill_line | input | LINE_W | Line index of the fill |
| fill_word | input | WORD_W | Word offset that caused the fill |
| acc_valid | input | 1 | A hit access to a line |
| acc_line | input | LINE_W | Line index of the access |
| acc_word | input | WORD_W | Word offset of the access |
| evict_valid | input | 1 | A line is being evicted |
| evict_line | input | LINE_W | Line index of the evict |
| ev_valid | output | 1 | One-cycle pulse: a tour record is present |
| ev_class | output | 2 | Reuse class {temporal, spatial} |
| ev_line | output | LINE_W | Index of the evicted line |
| ev_length | output | TS_W | Tour length in handled accesses |
| tour_cnt | output | 4*CNT_W | Saturating finished-tour counts, one slice per class |
| res_cnt | output | 4*RES_W | Resident-line census, one slice per class |

## Verification
The bench targets the following corner cases, and each one shows a distinct symptom when the design gets it wrong.

- A repeated fill to a resident line. A design that accepts it would restart the tour and shorten the reported length.
- A fill and an access to the same line in the same cycle. A design that takes both would report the line as temporal.
- An evict of an empty line that arrives together with a fill. A design that lets the fill through would create a resident line that the reference does not have.
- A clear that coincides with an eviction. A wrong priority leaves a count of one.
- Saturation of the tour counters and of the access clock, driven by long random runs. A wrapping counter shows up as a small count or a huge length.
- The census latency. An off-by-one-cycle census disagrees on every fill and evict.

// File: rtl/tour_pkg.sv
package tour_pkg;

  localparam int NUM_CLASSES = 4;
  localparam int CLASS_W     = 2;

  typedef enum logic [CLASS_W-1:0] {
    CLS_NTNS = 2'b00,
    CLS_NTS  = 2'b01,
    CLS_TNS  = 2'b10,
    CLS_TS   = 2'b11
  } tour_class_e;

endpackage

// File: rtl/tour_line_table.sv
module tour_line_table
  import tour_pkg::*;
#(
  parameter int NUM_LINES  = 16,
  parameter int LINE_WORDS = 8,
  parameter int TS_W       = 32,
  localparam int LINE_W    = $clog2(NUM_LINES),
  localparam int WORD_W    = $clog2(LINE_WORDS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fill_valid,
  input  logic [LINE_W-1:0]         fill_line,
  input  logic [WORD_W-1:0]         fill_word,
  input  logic                      acc_valid,
  input  logic [LINE_W-1:0]         acc_line,
  input  logic [WORD_W-1:0]         acc_word,
  input  logic                      evict_valid,
  input  logic [LINE_W-1:0]         evict_line,
  output logic                      fire_o,
  output logic [CLASS_W-1:0]        fire_class_o,
  output logic                      ev_valid_o,
  output logic [CLASS_W-1:0]        ev_class_o,
  output logic [LINE_W-1:0]         ev_line_o,
  output logic [TS_W-1:0]           ev_length_o,
  output logic [NUM_LINES-1:0]      line_valid_o,
  output logic [CLASS_W*NUM_LINES-1:0] line_class_o
);

  localparam logic [TS_W-1:0] TS_MAX = '1;

  logic [NUM_LINES-1:0]            valid_all;
  logic [NUM_LINES-1:0]            reuse_all;
  logic [LINE_WORDS*NUM_LINES-1:0] mask_all;
  logic [TS_W*NUM_LINES-1:0]       start_all;
  logic [TS_W-1:0]                 clock_q;

  logic do_evict, do_fill, do_acc;
  logic [LINE_WORDS-1:0] sel_mask;
  logic [TS_W-1:0]       sel_start;
  logic                  sel_spatial;
  tour_class_e           sel_class;

  // One event per cycle: evict, then fill, then access.
  always_comb begin
    do_evict = evict_valid && valid_all[evict_line];
    do_fill  = !evict_valid && fill_valid && !valid_all[fill_line];
    do_acc   = !evict_valid && !fill_valid && acc_valid && valid_all[acc_line];
  end

  // Global handled-access clock, saturating.
  always_ff @(posedge clk) begin
    if (rst) begin
      clock_q <= '0;
    end else if ((do_fill || do_acc) && clock_q != TS_MAX) begin
      clock_q <= clock_q + TS_W'(1);
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic                  v_q;
    logic                  r_q;
    logic [LINE_WORDS-1:0] m_q;
    logic [TS_W-1:0]       s_q;
    logic                  hit_evict, hit_fill, hit_acc;
    logic [LINE_WORDS-1:0] acc_bit;

    always_comb begin
      hit_evict = do_evict && (evict_line == LINE_W'(i));
      hit_fill  = do_fill  && (fill_line  == LINE_W'(i));
      hit_acc   = do_acc   && (acc_line   == LINE_W'(i));
      acc_bit   = LINE_WORDS'(1) << acc_word;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        r_q <= 1'b0;
        m_q <= '0;
        s_q <= '0;
      end else if (hit_evict) begin
        v_q <= 1'b0;
        r_q <= 1'b0;
        m_q <= '0;
      end else if (hit_fill) begin
        v_q <= 1'b1;
        r_q <= 1'b0;
        m_q <= LINE_WORDS'(1) << fill_word;
        s_q <= clock_q;
      end else if (hit_acc) begin
        r_q <= r_q | ((m_q & acc_bit) != '0);
        m_q <= m_q | acc_bit;
      end
    end

    assign valid_all[i]                       = v_q;
    assign reuse_all[i]                       = r_q;
    assign mask_all[i*LINE_WORDS +: LINE_WORDS] = m_q;
    assign start_all[i*TS_W +: TS_W]          = s_q;
    assign line_class_o[i*CLASS_W +: CLASS_W] = {r_q, ((m_q & (m_q - LINE_WORDS'(1))) != '0)};
  end

  always_comb begin
    sel_mask    = mask_all[evict_line*LINE_WORDS +: LINE_WORDS];
    sel_start   = start_all[evict_line*TS_W +: TS_W];
    sel_spatial = (sel_mask & (sel_mask - LINE_WORDS'(1))) != '0;
    sel_class   = tour_class_e'({reuse_all[evict_line], sel_spatial});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_valid_o  <= 1'b0;
      ev_class_o  <= '0;
      ev_line_o   <= '0;
      ev_length_o <= '0;
    end else begin
      ev_valid_o <= do_evict;
      if (do_evict) begin
        ev_class_o  <= sel_class;
        ev_line_o   <= evict_line;
        ev_length_o <= clock_q - sel_start;
      end
    end
  end

  assign fire_o       = do_evict;
  assign fire_class_o = sel_class;
  assign line_valid_o = valid_all;

endmodule

// File: rtl/tour_class_counters.sv
module tour_class_counters
  import tour_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         inc_valid,
  input  logic [CLASS_W-1:0]           inc_class,
  output logic [NUM_CLASSES*CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        cnt_q <= '0;
      end else if (inc_valid && inc_class == CLASS_W'(c) && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end

    assign cnt_o[c*CNT_W +: CNT_W] = cnt_q;
  end

endmodule

// File: rtl/tour_resident_census.sv
module tour_resident_census
  import tour_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int RES_W     = 5
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_LINES-1:0]              line_valid,
  input  logic [CLASS_W*NUM_LINES-1:0]      line_class,
  output logic [NUM_CLASSES*RES_W-1:0]      res_o
);

  logic [RES_W-1:0] tally [NUM_CLASSES];
  logic [RES_W-1:0] res_q [NUM_CLASSES];

  always_comb begin
    for (int c = 0; c < NUM_CLASSES; c++) begin
      tally[c] = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
        if (line_valid[i] && line_class[i*CLASS_W +: CLASS_W] == CLASS_W'(c)) begin
          tally[c] = tally[c] + RES_W'(1);
        end
      end
    end
  end

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_res
    always_ff @(posedge clk) begin
      if (rst) res_q[c] <= '0;
      else     res_q[c] <= tally[c];
    end
    assign res_o[c*RES_W +: RES_W] = res_q[c];
  end

endmodule

// File: rtl/tour_reuse_classifier.sv
module tour_reuse_classifier
  import tour_pkg::*;
#(
  parameter int NUM_LINES  = 16,
  parameter int LINE_WORDS = 8,
  parameter int TS_W       = 32,
  parameter int CNT_W      = 32,
  localparam int LINE_W    = $clog2(NUM_LINES),
  localparam int WORD_W    = $clog2(LINE_WORDS),
  localparam int RES_W     = $clog2(NUM_LINES + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr_cnt,
  input  logic                         fill_valid,
  input  logic [LINE_W-1:0]            fill_line,
  input  logic [WORD_W-1:0]            fill_word,
  input  logic                         acc_valid,
  input  logic [LINE_W-1:0]            acc_line,
  input  logic [WORD_W-1:0]            acc_word,
  input  logic                         evict_valid,
  input  logic [LINE_W-1:0]            evict_line,
  output logic                         ev_valid,
  output logic [1:0]                   ev_class,
  output logic [LINE_W-1:0]            ev_line,
  output logic [TS_W-1:0]              ev_length,
  output logic [4*CNT_W-1:0]           tour_cnt,
  output logic [4*RES_W-1:0]           res_cnt
);

  logic                         fire;
  logic [CLASS_W-1:0]           fire_class;
  logic [NUM_LINES-1:0]         line_valid;
  logic [CLASS_W*NUM_LINES-1:0] line_class;

  tour_line_table #(
    .NUM_LINES (NUM_LINES),
    .LINE_WORDS(LINE_WORDS),
    .TS_W      (TS_W)
  ) table_i (
    .clk         (clk),
    .rst         (rst),
    .fill_valid  (fill_valid),
    .fill_line   (fill_line),
    .fill_word   (fill_word),
    .acc_valid   (acc_valid),
    .acc_line    (acc_line),
    .acc_word    (acc_word),
    .evict_valid (evict_valid),
    .evict_line  (evict_line),
    .fire_o      (fire),
    .fire_class_o(fire_class),
    .ev_valid_o  (ev_valid),
    .ev_class_o  (ev_class),
    .ev_line_o   (ev_line),
    .ev_length_o (ev_length),
    .line_valid_o(line_valid),
    .line_class_o(line_class)
  );

  tour_class_counters #(
    .CNT_W(CNT_W)
  ) counters_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr_cnt),
    .inc_valid(fire),
    .inc_class(fire_class),
    .cnt_o    (tour_cnt)
  );

  tour_resident_census #(
    .NUM_LINES(NUM_LINES),
    .RES_W    (RES_W)
  ) census_i (
    .clk       (clk),
    .rst       (rst),
    .line_valid(line_valid),
    .line_class(line_class),
    .res_o     (res_cnt)
  );

endmodule

// File: rtl/tour_reuse_classifier_chk.sv
module tour_reuse_classifier_chk #(
  parameter int NUM_LINES = 16,
  parameter int TS_W      = 32,
  parameter int CNT_W     = 32,
  localparam int LINE_W   = $clog2(NUM_LINES),
  localparam int RES_W    = $clog2(NUM_LINES + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_cnt,
  input logic              evict_valid,
  input logic [LINE_W-1:0] evict_line,
  input logic              ev_valid,
  input logic [LINE_W-1:0] ev_line,
  input logic [TS_W-1:0]   ev_length,
  input logic [4*CNT_W-1:0] tour_cnt,
  input logic [4*RES_W-1:0] res_cnt
);

  int res_sum;

  always_comb begin
    res_sum = 0;
    for (int c = 0; c < 4; c++) res_sum += int'(res_cnt[c*RES_W +: RES_W]);
  end

  AST_EV_NEEDS_EVICT: assert property (@(posedge clk) disable iff (rst) ev_valid |-> $past(evict_valid)); // R4
  AST_EV_LINE_ECHO: assert property (@(posedge clk) disable iff (rst) ev_valid |-> ev_line == $past(evict_line)); // R4
  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst) $past(clr_cnt) |-> tour_cnt == '0); // R9
  AST_CNT_QUIET: assert property (@(posedge clk) disable iff (rst) (!$past(evict_valid) && !$past(clr_cnt)) |-> $stable(tour_cnt)); // R8

  always_ff @(posedge clk) begin
    if (!rst) begin
      AST_RES_BOUND: assert (res_sum <= NUM_LINES); // R10
    end
  end

endmodule

bind tour_reuse_classifier tour_reuse_classifier_chk #(
  .NUM_LINES(NUM_LINES),
  .TS_W     (TS_W),
  .CNT_W    (CNT_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .clr_cnt    (clr_cnt),
  .evict_valid(evict_valid),
  .evict_line (evict_line),
  .ev_valid   (ev_valid),
  .ev_line    (ev_line),
  .ev_length  (ev_length),
  .tour_cnt   (tour_cnt),
  .res_cnt    (res_cnt)
);

// File: tb/tour_reuse_classifier_tb_top.sv
module tour_reuse_classifier_tb_top;

  localparam int NL  = 8;
  localparam int NW  = 8;
  localparam int TSW = 8;
  localparam int CW  = 4;
  localparam int LW  = 3;
  localparam int WW  = 3;
  localparam int RW  = 4;
  localparam int TS_SAT  = (1 << TSW) - 1;
  localparam int CNT_SAT = (1 << CW) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, clr_cnt, fill_valid, acc_valid, evict_valid;
  logic [LW-1:0] fill_line, acc_line, evict_line;
  logic [WW-1:0] fill_word, acc_word;
  logic ev_valid;
  logic [1:0] ev_class;
  logic [LW-1:0] ev_line;
  logic [TSW-1:0] ev_length;
  logic [4*CW-1:0] tour_cnt;
  logic [4*RW-1:0] res_cnt;

  tour_reuse_classifier #(
    .NUM_LINES(NL), .LINE_WORDS(NW), .TS_W(TSW), .CNT_W(CW)
  ) dut_i (
    .clk(clk), .rst(rst), .clr_cnt(clr_cnt),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_word(fill_word),
    .acc_valid(acc_valid), .acc_line(acc_line), .acc_word(acc_word),
    .evict_valid(evict_valid), .evict_line(evict_line),
    .ev_valid(ev_valid), .ev_class(ev_class), .ev_line(ev_line),
    .ev_length(ev_length), .tour_cnt(tour_cnt), .res_cnt(res_cnt)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit armed    = 1'b0;

  // Behavioural reference
  int m_valid [NL];
  int m_mask  [NL];
  int m_reuse [NL];
  int m_start [NL];
  int g_clock;
  int e_tour [4];
  int e_res  [4];
  bit e_ev;
  int e_cls, e_line, e_len;

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(ev_valid == e_ev, "R4/R6/R7 ev_valid", ev_valid, e_ev);
    if (e_ev && ev_valid) begin
      check(int'(ev_class) == e_cls, "R2/R3/R4 ev_class", ev_class, e_cls);
      check(int'(ev_line) == e_line, "R4 ev_line", ev_line, e_line);
      check(int'(ev_length) == e_len, "R5/R12 ev_length", ev_length, e_len);
    end
    for (int c = 0; c < 4; c++) begin
      check(int'(tour_cnt[c*CW +: CW]) == e_tour[c], "R8/R9 tour count", tour_cnt[c*CW +: CW], e_tour[c]);
      check(int'(res_cnt[c*RW +: RW]) == e_res[c], "R1/R10 resident count", res_cnt[c*RW +: RW], e_res[c]);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NL; i++) begin
      m_valid[i] = 0; m_mask[i] = 0; m_reuse[i] = 0; m_start[i] = 0;
    end
    g_clock = 0;
    for (int c = 0; c < 4; c++) begin e_tour[c] = 0; e_res[c] = 0; end
    e_ev = 0; e_cls = 0; e_line = 0; e_len = 0;
  endtask

  task automatic step(bit r, bit clr, bit fv, int fl, int fw, bit av, int al, int aw, bit ev, int el);
    if (armed) compare_all();
    rst = r; clr_cnt = clr;
    fill_valid = fv; fill_line = LW'(fl); fill_word = WW'(fw);
    acc_valid = av; acc_line = LW'(al); acc_word = WW'(aw);
    evict_valid = ev; evict_line = LW'(el);
    if (r) begin
      model_reset();
    end else begin
      for (int c = 0; c < 4; c++) e_res[c] = 0;
      for (int i = 0; i < NL; i++) begin
        if (m_valid[i] != 0) begin
          int k;
          k = m_reuse[i] * 2 + (($countones(m_mask[i]) > 1) ? 1 : 0);
          e_res[k]++;
        end
      end
      e_ev = 0;
      if (ev) begin
        if (m_valid[el] != 0) begin
          e_ev   = 1;
          e_cls  = m_reuse[el] * 2 + (($countones(m_mask[el]) > 1) ? 1 : 0);
          e_line = el;
          e_len  = g_clock - m_start[el];
          if (e_tour[e_cls] < CNT_SAT) e_tour[e_cls]++;
          m_valid[el] = 0; m_mask[el] = 0; m_reuse[el] = 0;
        end
      end else if (fv) begin
        if (m_valid[fl] == 0) begin
          m_valid[fl] = 1; m_mask[fl] = 1 << fw; m_reuse[fl] = 0;
          m_start[fl] = g_clock;
          if (g_clock < TS_SAT) g_clock++;
        end
      end else if (av) begin
        if (m_valid[al] != 0) begin
          if ((m_mask[al] & (1 << aw)) != 0) m_reuse[al] = 1;
          m_mask[al] = m_mask[al] | (1 << aw);
          if (g_clock < TS_SAT) g_clock++;
        end
      end
      if (clr) for (int c = 0; c < 4; c++) e_tour[c] = 0;
    end
    @(negedge clk);
  endtask

  task automatic idle();            step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic fill(int l, int w); step(0, 0, 1, l, w, 0, 0, 0, 0, 0); endtask
  task automatic acc(int l, int w);  step(0, 0, 0, 0, 0, 1, l, w, 0, 0); endtask
  task automatic evict(int l);       step(0, 0, 0, 0, 0, 0, 0, 0, 1, l); endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog expired act=0 exp=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; clr_cnt = 1'b0;
    fill_valid = 1'b0; acc_valid = 1'b0; evict_valid = 1'b0;
    fill_line = '0; fill_word = '0; acc_line = '0; acc_word = '0; evict_line = '0;
    model_reset();
    @(negedge clk);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    armed = 1'b1;
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    idle();
    // R11: all outputs cleared after reset
    check(ev_valid == 1'b0 && tour_cnt == '0 && res_cnt == '0, "R11 reset state",
          {ev_valid, tour_cnt, res_cnt}, 0);

    // R3/R2 class NTNS, R5 length 1
    fill(1, 2); idle(); evict(1); idle();
    // R2 temporal, nonspatial
    fill(2, 0); acc(2, 0); evict(2); idle();
    // R3 spatial, nontemporal, with other-line traffic counted in length (R5)
    fill(3, 1); fill(6, 4); acc(3, 5); acc(6, 4); evict(3); idle();
    // TS class
    fill(4, 0); acc(4, 1); acc(4, 1); acc(4, 7); evict(4); idle(); idle();
    // R6: ignored events
    acc(5, 3); evict(5); fill(5, 3); fill(5, 4); acc(0, 1); evict(5); idle();
    evict(6); idle();
    // R7: priority
    step(0, 0, 1, 0, 0, 0, 0, 0, 1, 0);   // evict empty line 0 blocks fill
    step(0, 0, 1, 0, 0, 1, 0, 0, 0, 0);   // fill wins over access
    idle(); evict(0); idle();
    // R9: clear overrides simultaneous increment
    fill(7, 2); step(0, 1, 0, 0, 0, 0, 0, 0, 1, 7); idle(); idle();

    // Random traffic, then a mid-run reset and more traffic (R8, R12 saturation)
    for (int phase = 0; phase < 2; phase++) begin
      for (int n = 0; n < 2500; n++) begin
        bit fv, av, ev, clr;
        fv  = ($urandom_range(0, 3) == 0);
        av  = ($urandom_range(0, 1) == 0);
        ev  = ($urandom_range(0, 5) == 0);
        clr = ($urandom_range(0, 127) == 0);
        step(0, clr, fv, $urandom_range(0, NL-1), $urandom_range(0, NW-1),
             av, $urandom_range(0, NL-1), $urandom_range(0, NW-1),
             ev, $urandom_range(0, NL-1));
      end
      step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      idle();
    end

    idle(); idle();
    compare_all();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule